// File: doc/BRIEF.md
# Register-Driven SPI Shift Engine

A SPI master that software drives through four word-wide registers: an enable register that connects the engine to the pins, a control register that launches a shift, a transmit word and a receive word. Software loads the transmit word and then writes the control register. That write gives a bit count, a chip-select choice, an idle clock level, a release flag and a start bit. The engine sends the low N bits of the transmit word MSB-first and shifts the bits it samples from the slave into the receive word.

The selected chip select stays low after a shift unless the release flag was given. Software can therefore build a long flash command, such as an opcode, an address and many data bytes, out of a series of short shifts. A release shift with a count of zero moves no clock and only raises the chip select.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset all three `spi_cs_n` lines are high, `spi_sck` and `spi_mosi` are low, `busy` is low and the receive word (address 3) reads 0.
- R2: Register addresses are 0 for enable (bit 0), 1 for control, 2 for the transmit word and 3 for the receive word. Control bit 31 is start, bits 30/29/28 select chip select 2/1/0, bit 27 is the idle clock level, bit 26 is release and bits 6:0 are the bit count. Reading address 1 returns busy in bit 31.
- R3: A control write with start set while enable is 1 produces exactly N leading clock edges, for a count N from 1 to 32. On those edges `spi_mosi` carries bits N-1 down to 0 of the transmit word.
- R4: Each bit is sampled from `spi_miso` on the leading clock edge and enters bit 0 of the receive word. Earlier bits move up, so after an N-bit shift the receive word equals (old << N) | received bits.
- R5: The clock rests at the idle level given in control bit 27. Data leaves on the trailing edge and is sampled on the leading edge (mode 0 when the idle level is 0).
- R6: Only one chip select is driven low. If several select bits are set, the lowest-numbered one wins. If none is set, chip select 0 is used.
- R7: After a shift with release set, all chip selects are high. Without release, the chosen chip select stays low once the shift ends.
- R8: A start with count 0 and release set produces no clock edge, leaves the receive word unchanged and raises all chip selects. With count 0 and release clear, the chosen chip select is driven low.
- R9: `busy` is high from the cycle after the start write until the last bit's trailing edge. Writes to control or the transmit word while busy are ignored.
- R10: A control write with start clear raises all chip selects. With enable 0, `spi_cs_n` is 3'b111 and `spi_sck` and `spi_mosi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| busy | output | 1 | Shift in progress |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
The embedded assertions check four rules on every cycle: at most one chip select is low, some chip select is low whenever busy is high, the clock does not move while idle, and the receive word does not change outside a shift. They also check that a shift marked for release ends with every select high. Whether the right bits leave in the right order, how the receive word accumulates, which select wins, and the count-zero and write-while-busy cases can only be shown by the bench. The bench loops MOSI back to MISO and sweeps every count from 1 to 32 at both idle clock levels. It compares the captured serial bits and the receive word with values it computes arithmetically.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [2:0]  spi_cs_n
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

  logic        en_q, term_q, cpol_q, ph_q, busy_q;
  logic [2:0]  cs_q;
  logic [6:0]  left_q;
  logic [DW-1:0] div_q;
  logic [31:0] sh_q, tx_q, rx_q, ctrl_q;

  wire       ctl_wr = reg_we && reg_addr == 2'd1 && !busy_q;
  wire       start  = ctl_wr && reg_wdata[31] && en_q;
  wire [6:0] n      = reg_wdata[6:0];
  wire       tick   = busy_q && div_q == DIV_LAST;

  logic [2:0]  sel;
  logic [31:0] load;
  always_comb begin
    if (reg_wdata[28])      sel = 3'b001;
    else if (reg_wdata[29]) sel = 3'b010;
    else if (reg_wdata[30]) sel = 3'b100;
    else                    sel = 3'b001;
    load = (n >= 7'd32) ? tx_q : (tx_q << (7'd32 - n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; term_q <= 1'b0; cpol_q <= 1'b0; ph_q <= 1'b0; busy_q <= 1'b0;
      cs_q <= 3'b000; left_q <= '0; div_q <= '0;
      sh_q <= '0; tx_q <= '0; rx_q <= '0; ctrl_q <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd0) en_q <= reg_wdata[0];
      if (reg_we && reg_addr == 2'd2 && !busy_q) tx_q <= reg_wdata;
      if (ctl_wr) begin
        ctrl_q <= reg_wdata;
        cpol_q <= reg_wdata[27];
        term_q <= reg_wdata[26];
        if (start) begin
          sh_q   <= load;
          left_q <= n;
          div_q  <= '0;
          ph_q   <= 1'b0;
          busy_q <= (n != 7'd0);
          cs_q   <= (n == 7'd0 && reg_wdata[26]) ? 3'b000 : sel;
        end else begin
          cs_q <= 3'b000;
        end
      end else if (busy_q) begin
        if (tick) begin
          div_q <= '0;
          ph_q  <= ~ph_q;
          if (!ph_q) begin
            rx_q <= {rx_q[30:0], spi_miso};
          end else begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - 7'd1;
            if (left_q == 7'd1) begin
              busy_q <= 1'b0;
              if (term_q) cs_q <= 3'b000;
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {31'b0, en_q};
      2'd1:    reg_rdata = {busy_q, ctrl_q[30:0]};
      2'd2:    reg_rdata = tx_q;
      default: reg_rdata = rx_q;
    endcase
  end

  assign busy     = busy_q;
  assign spi_sck  = en_q & (cpol_q ^ ph_q);
  assign spi_mosi = en_q & busy_q & sh_q[31];
  assign spi_cs_n = en_q ? ~cs_q : 3'b111;

  assert_one_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  assert_cs_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en_q) |-> (spi_cs_n != 3'b111));
  assert_release_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && term_q && en_q) |-> (spi_cs_n == 3'b111));
  assert_idle_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_we) |=> $stable(spi_sck));
  assert_rx_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rx_q));
endmodule

// File: tb/sim_spi_shift_engine.sv
module sim_spi_shift_engine;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic busy, spi_sck, spi_mosi, spi_miso;
  logic [2:0] spi_cs_n;
  int checks = 0, fails = 0;
  int lead_cnt = 0, bad_cs = 0;
  logic [31:0] cap = 0;
  logic cpol_b = 0, prev_sck = 0;
  logic [31:0] exp_rx = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign spi_miso = spi_mosi;

  spi_shift_engine #(.HALF(2)) u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  always @(negedge clk) begin
    if (spi_sck !== prev_sck && spi_sck !== cpol_b) begin
      lead_cnt++;
      cap = {cap[30:0], spi_mosi};
      if (spi_cs_n == 3'b111) bad_cs++;
    end
    prev_sck = spi_sck;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; #1;
  endtask

  function automatic logic [31:0] ctl(input int n, input bit term, input logic [2:0] csb, input bit pol);
    return {1'b1, csb, pol, term, 19'b0, 7'(n)};
  endfunction

  function automatic logic [2:0] pick(input logic [2:0] csb);
    if (csb[0]) return 3'b001;
    if (csb[1]) return 3'b010;
    if (csb[2]) return 3'b100;
    return 3'b001;
  endfunction

  task automatic xfer(input logic [31:0] d, input int n, input bit term, input logic [2:0] csb, input bit pol);
    wr(2'd2, d);
    cpol_b = pol; lead_cnt = 0; cap = 0; bad_cs = 0;
    wr(2'd1, ctl(n, term, csb, pol));
    for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
    #1;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] d, m;
    logic [2:0] ecs;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 3'b111 && spi_sck == 0 && spi_mosi == 0 && busy == 0, "R1 pins", {spi_cs_n, spi_sck, spi_mosi, busy}, 32'h38);
    rst_n = 1;
    reg_addr = 2'd3; #1;
    chk(reg_rdata == 0, "R1 rx word", reg_rdata, 0);
    wr(2'd0, 32'h1);
    // R3 R4 R5 R7 sweep over counts and idle levels
    for (int pol = 0; pol < 2; pol++) begin
      for (int n = 1; n <= 32; n++) begin
        d = 32'hA5C3_96E1 ^ (32'h1357_9BDF * n) ^ (pol ? 32'hFFFF_0000 : 0);
        m = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
        xfer(d, n, n[0], 3'b001 << (n % 3), pol[0]);
        chk(lead_cnt == n, "R3 edge count", lead_cnt, n);
        chk(cap == (d & m), "R3 mosi bits", cap, d & m);
        exp_rx = (n == 32) ? d : ((exp_rx << n) | (d & m));
        reg_addr = 2'd3; #1;
        chk(reg_rdata == exp_rx, "R4 rx word", reg_rdata, exp_rx);
        ecs = n[0] ? 3'b111 : ~(3'b001 << (n % 3));
        chk(spi_cs_n == ecs && bad_cs == 0, "R7 cs after shift", spi_cs_n, ecs);
        chk(spi_sck == pol[0], "R5 idle clock", spi_sck, pol);
      end
    end
    // R6 lowest select wins
    for (int c = 0; c < 8; c++) begin
      xfer(32'h5A, 8, 0, 3'(c), 0);
      exp_rx = (exp_rx << 8) | 32'h5A;
      chk(spi_cs_n == ~pick(3'(c)), "R6 select choice", spi_cs_n, ~pick(3'(c)));
    end
    // R8 zero-length release
    xfer(32'hFFFF_FFFF, 0, 1, 3'b010, 0);
    reg_addr = 2'd3; #1;
    chk(lead_cnt == 0 && spi_cs_n == 3'b111, "R8 release only", {spi_cs_n, 8'(lead_cnt)}, 32'h700);
    chk(reg_rdata == exp_rx, "R8 rx unchanged", reg_rdata, exp_rx);
    xfer(32'h0, 0, 0, 3'b100, 0);
    chk(lead_cnt == 0 && spi_cs_n == 3'b011, "R8 select only", {spi_cs_n, 8'(lead_cnt)}, 32'h300);
    // R9 busy and writes while busy
    wr(2'd2, 32'h0000_BEEF);
    lead_cnt = 0; cap = 0; cpol_b = 0;
    wr(2'd1, ctl(16, 1, 3'b001, 0));
    chk(busy == 1, "R9 busy port", busy, 1);
    reg_addr = 2'd1; #1;
    chk(reg_rdata[31] == 1, "R9 busy readback R2", reg_rdata, 32'h8000_0000);
    wr(2'd1, ctl(4, 0, 3'b100, 1));
    wr(2'd2, 32'h0000_1234);
    for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
    #1;
    chk(lead_cnt == 16 && cap == 32'hBEEF, "R9 writes ignored", cap, 32'hBEEF);
    chk(spi_cs_n == 3'b111, "R9 original release kept", spi_cs_n, 3'b111);
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 32'hBEEF, "R9 tx unchanged R2", reg_rdata, 32'hBEEF);
    // R10 shutdown
    xfer(32'h3, 2, 0, 3'b010, 1);
    chk(spi_cs_n == 3'b101, "R10 held before stop", spi_cs_n, 3'b101);
    wr(2'd1, 32'h0);
    chk(spi_cs_n == 3'b111, "R10 stop releases", spi_cs_n, 3'b111);
    xfer(32'h1, 1, 0, 3'b001, 1);
    wr(2'd0, 32'h0);
    chk(spi_cs_n == 3'b111 && spi_sck == 0 && spi_mosi == 0, "R10 disabled pins", {spi_cs_n, spi_sck, spi_mosi}, 32'h1C);
    reg_addr = 2'd0; #1;
    chk(reg_rdata == 0, "R10 enable readback R2", reg_rdata, 0);
    finish_up();
  end
endmodule